// File: doc/BRIEF.md
# Multi-source analog switch controller

This block commands four analog switches: two single-throw switches that connect or isolate output buffers, and two double-throw switches, each with a normally-open and a normally-closed terminal. A small control register gives the software-driven part of each command. Each switch can also be driven by any of a set of general-purpose pin inputs and by a PWM signal. Each pin has its own active level. Each pin and the PWM are assigned to each switch separately.

Each switch's effective control is the OR of three terms: its register bit, every pin assigned to it that is at its active level, and the PWM when the PWM is assigned to that switch and at the level chosen for that switch. A single-throw switch closes on that effective control. A double-throw switch has its own mode bit. With the mode bit at 0, both terminals open and close together. With the mode bit at 1, the two terminals are always in opposite states. The switch commands are combinational from the register and the live pin and PWM inputs. A write reaches the register on the next clock edge.

Top module: `aswc_top`

## Requirements
- R1: After reset the register reads 8'h00. With no pin or PWM assigned, every switch output is then 0 (open).
- R2: When wr_en_i is high at a rising clock edge, bits [7:2] of wr_data_i are stored. rd_data_o then returns them in [7:2], with [1:0] always 0. Layout: [7] single-throw A, [6] single-throw B, [5] double-throw 1 mode, [4] double-throw 1 control, [3] double-throw 2 mode, [2] double-throw 2 control.
- R3: Without wr_en_i the register keeps its value.
- R4: A single-throw output is 1 when its register bit is 1, when an assigned pin is asserted, or when the assigned PWM is asserted. It is 0 only when all three are off.
- R5: A pin counts as asserted when pin_i equals pin_act_hi_i for that pin. With pin_act_hi_i at 0, the pin is asserted when it is driven low.
- R6: A pin whose assignment bit for a switch is 0 has no effect on that switch. The PWM likewise has no effect on a switch whose pwm_sel_i bit is 0.
- R7: An assigned PWM counts as asserted when pwm_i equals pwm_pol_i for that switch. The index order for pwm_sel_i and pwm_pol_i is 0 for A, 1 for B, 2 for double-throw 1 and 3 for double-throw 2.
- R8: With a double-throw mode bit of 0, both terminals equal the effective control.
- R9: With a double-throw mode bit of 1, the normally-open terminal equals the effective control and the normally-closed terminal equals its inverse.
- R10: Double-throw switch 2 uses its own mode bit, control bit, pin assignments and PWM bit, independent of switch 1.
- R11: The outputs follow pin and PWM changes in the same cycle. A register write changes the outputs only after the capturing clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| pin_i | input | NPIN | Live general-purpose pin levels |
| pin_act_hi_i | input | NPIN | Per-pin active level, 1 = high asserts |
| pin_to_sta_i | input | NPIN | Pins assigned to single-throw A |
| pin_to_stb_i | input | NPIN | Pins assigned to single-throw B |
| pin_to_dt1_i | input | NPIN | Pins assigned to double-throw 1 |
| pin_to_dt2_i | input | NPIN | Pins assigned to double-throw 2 |
| pwm_i | input | 1 | PWM level |
| pwm_sel_i | input | 4 | PWM assigned per switch |
| pwm_pol_i | input | 4 | PWM level that asserts, per switch |
| sta_close_o | output | 1 | Single-throw A closed |
| stb_close_o | output | 1 | Single-throw B closed |
| dt1_no_close_o | output | 1 | Double-throw 1 normally-open terminal closed |
| dt1_nc_close_o | output | 1 | Double-throw 1 normally-closed terminal closed |
| dt2_no_close_o | output | 1 | Double-throw 2 normally-open terminal closed |
| dt2_nc_close_o | output | 1 | Double-throw 2 normally-closed terminal closed |

## Verification
The assertions check four properties on every cycle. First, a write is captured and held. Second, a set register bit always closes its single-throw switch. Third, a switch with nothing assigned and its bit clear stays open. Fourth, the double-throw terminals match in mode 0 and differ in mode 1. The bench scenarios are needed for the rest: the full OR across active-low pins and PWM polarity, the independence of the second double-throw switch, and the timing of a write against the clock edge. The bench compares random pin, assignment and PWM patterns against a reference model, and adds directed cases for each of these.

// File: rtl/aswc_pkg.sv
package aswc_pkg;
  localparam int SW_NUM = 4;
  localparam int IDX_STA = 0;
  localparam int IDX_STB = 1;
  localparam int IDX_DT1 = 2;
  localparam int IDX_DT2 = 3;
  localparam int REG_W   = 8;

  // field order is the register bit order [7:2]
  typedef struct packed {
    logic sta;
    logic stb;
    logic dt1_mode;
    logic dt1_ctl;
    logic dt2_mode;
    logic dt2_ctl;
  } swreg_t;
endpackage

// File: rtl/aswc_reg.sv
module aswc_reg
  import aswc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output swreg_t           q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (wr_en_i) q_o <= swreg_t'(wr_data_i[REG_W-1:2]);
  end
endmodule

// File: rtl/aswc_src.sv
module aswc_src #(
  parameter int NPIN = 4
) (
  input  logic            bit_i,
  input  logic [NPIN-1:0] pin_i,
  input  logic [NPIN-1:0] pin_act_hi_i,
  input  logic [NPIN-1:0] pin_sel_i,
  input  logic            pwm_i,
  input  logic            pwm_sel_i,
  input  logic            pwm_pol_i,
  output logic            eff_o
);
  logic [NPIN-1:0] pin_asserted;
  logic            pwm_asserted;

  assign pin_asserted = ~(pin_i ^ pin_act_hi_i) & pin_sel_i;
  assign pwm_asserted = pwm_sel_i & ~(pwm_i ^ pwm_pol_i);
  assign eff_o        = bit_i | (|pin_asserted) | pwm_asserted;
endmodule

// File: rtl/aswc_dt.sv
module aswc_dt (
  input  logic mode_i,
  input  logic eff_i,
  output logic no_close_o,
  output logic nc_close_o
);
  assign no_close_o = eff_i;
  assign nc_close_o = mode_i ? ~eff_i : eff_i;
endmodule

// File: rtl/aswc_top.sv
module aswc_top
  import aswc_pkg::*;
#(
  parameter int NPIN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic [NPIN-1:0]  pin_i,
  input  logic [NPIN-1:0]  pin_act_hi_i,
  input  logic [NPIN-1:0]  pin_to_sta_i,
  input  logic [NPIN-1:0]  pin_to_stb_i,
  input  logic [NPIN-1:0]  pin_to_dt1_i,
  input  logic [NPIN-1:0]  pin_to_dt2_i,
  input  logic             pwm_i,
  input  logic [SW_NUM-1:0] pwm_sel_i,
  input  logic [SW_NUM-1:0] pwm_pol_i,
  output logic             sta_close_o,
  output logic             stb_close_o,
  output logic             dt1_no_close_o,
  output logic             dt1_nc_close_o,
  output logic             dt2_no_close_o,
  output logic             dt2_nc_close_o
);
  swreg_t            ctl_q;
  logic [NPIN-1:0]   sel   [SW_NUM];
  logic [SW_NUM-1:0] bits;
  logic [SW_NUM-1:0] eff;
  logic [1:0]        dt_mode;
  logic [1:0]        dt_no;
  logic [1:0]        dt_nc;

  aswc_reg u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .q_o      (ctl_q)
  );

  assign rd_data_o = {ctl_q, 2'b00};

  assign sel[IDX_STA] = pin_to_sta_i;
  assign sel[IDX_STB] = pin_to_stb_i;
  assign sel[IDX_DT1] = pin_to_dt1_i;
  assign sel[IDX_DT2] = pin_to_dt2_i;

  assign bits[IDX_STA] = ctl_q.sta;
  assign bits[IDX_STB] = ctl_q.stb;
  assign bits[IDX_DT1] = ctl_q.dt1_ctl;
  assign bits[IDX_DT2] = ctl_q.dt2_ctl;
  assign dt_mode       = {ctl_q.dt2_mode, ctl_q.dt1_mode};

  for (genvar g = 0; g < SW_NUM; g++) begin : g_src
    aswc_src #(.NPIN(NPIN)) u_src (
      .bit_i       (bits[g]),
      .pin_i       (pin_i),
      .pin_act_hi_i(pin_act_hi_i),
      .pin_sel_i   (sel[g]),
      .pwm_i       (pwm_i),
      .pwm_sel_i   (pwm_sel_i[g]),
      .pwm_pol_i   (pwm_pol_i[g]),
      .eff_o       (eff[g])
    );
  end

  for (genvar d = 0; d < 2; d++) begin : g_dt
    aswc_dt u_dt (
      .mode_i    (dt_mode[d]),
      .eff_i     (eff[IDX_DT1+d]),
      .no_close_o(dt_no[d]),
      .nc_close_o(dt_nc[d])
    );
  end

  assign sta_close_o    = eff[IDX_STA];
  assign stb_close_o    = eff[IDX_STB];
  assign dt1_no_close_o = dt_no[0];
  assign dt1_nc_close_o = dt_nc[0];
  assign dt2_no_close_o = dt_no[1];
  assign dt2_nc_close_o = dt_nc[1];

  assert_wr_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o == {$past(wr_data_i[REG_W-1:2]), 2'b00});
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o));
  assert_bit_closes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[7] |-> sta_close_o) and (rd_data_o[6] |-> stb_close_o));
  assert_unassigned_open_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_data_o[7] && pin_to_sta_i == '0 && !pwm_sel_i[IDX_STA]) |-> !sta_close_o);
  assert_together_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[5] |-> (dt1_no_close_o == dt1_nc_close_o));
  assert_toggle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[5] |-> (dt1_no_close_o != dt1_nc_close_o));
  assert_dt2_mode_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[3] |-> (dt2_no_close_o != dt2_nc_close_o));
endmodule

// File: tb/aswc_top_bench.sv
`timescale 1ns/1ps
module aswc_top_bench;
  localparam int NPIN = 4;

  logic            clk = 0;
  logic            rst_n = 0;
  logic            wr_en = 0;
  logic [7:0]      wr_data = '0;
  logic [7:0]      rd_data;
  logic [NPIN-1:0] pin = '0, act_hi = '0, s_a = '0, s_b = '0, s_1 = '0, s_2 = '0;
  logic            pwm = 0;
  logic [3:0]      psel = '0, ppol = '0;
  logic            sta, stb, d1no, d1nc, d2no, d2nc;
  logic [5:0]      shadow = '0;
  int              n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  aswc_top #(.NPIN(NPIN)) u_aswc_top (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .pin_i(pin), .pin_act_hi_i(act_hi), .pin_to_sta_i(s_a), .pin_to_stb_i(s_b),
    .pin_to_dt1_i(s_1), .pin_to_dt2_i(s_2), .pwm_i(pwm), .pwm_sel_i(psel), .pwm_pol_i(ppol),
    .sta_close_o(sta), .stb_close_o(stb), .dt1_no_close_o(d1no), .dt1_nc_close_o(d1nc),
    .dt2_no_close_o(d2no), .dt2_nc_close_o(d2nc)
  );

  function automatic logic eff_f(logic b, logic [NPIN-1:0] s, int k);
    logic e = b;
    for (int i = 0; i < NPIN; i++)
      if (s[i] && (pin[i] == act_hi[i])) e = 1'b1;
    if (psel[k] && (pwm == ppol[k])) e = 1'b1;
    return e;
  endfunction

  // expected {sta, stb, d1no, d1nc, d2no, d2nc}
  function automatic logic [5:0] model(logic [5:0] r);
    logic a, b, e1, e2;
    a  = eff_f(r[5], s_a, 0);
    b  = eff_f(r[4], s_b, 1);
    e1 = eff_f(r[2], s_1, 2);
    e2 = eff_f(r[0], s_2, 3);
    return {a, b, e1, r[3] ? ~e1 : e1, e2, r[1] ? ~e2 : e2};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_out(string tag);
    check(tag, {2'b0, sta, stb, d1no, d1nc, d2no, d2nc}, {2'b0, model(shadow)});
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0; shadow = d[7:2];
    #1;
  endtask

  task automatic clear_src();
    @(negedge clk);
    pin = '0; act_hi = '0; s_a = '0; s_b = '0; s_1 = '0; s_2 = '0;
    psel = '0; ppol = '0; pwm = 0;
    #1;
  endtask

  initial begin
    #200000;
    n_fail++; n_run++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 reset read", rd_data, 8'h00);
    check("R1 reset outputs", {2'b0, sta, stb, d1no, d1nc, d2no, d2nc}, 8'h00);

    // R2 layout and low bits
    wr(8'hFF); check("R2 read all ones", rd_data, 8'hFC);
    check_out("R4/R9 all bits set");
    wr(8'h00); check_out("R8 all clear");

    // R5 active-low pin on A
    clear_src(); @(negedge clk); s_a = 4'b0001; act_hi = 4'b0000; pin = 4'b1110; #1;
    check("R5 active-low asserted", {7'b0, sta}, 8'h01);
    @(negedge clk); pin = 4'b0001; #1;
    check("R5 active-low released", {7'b0, sta}, 8'h00);

    // R6 unassigned pin and PWM ignored
    clear_src(); @(negedge clk); act_hi = '1; pin = '1; s_b = '1; pwm = 1; ppol = '1; psel = 4'b0010; #1;
    check("R6 unassigned ignored", {2'b0, sta, stb, d1no, d1nc, d2no, d2nc}, 8'b0001_0000);

    // R7 PWM polarity on dt1 in mode 0
    clear_src(); @(negedge clk); psel = 4'b0100; ppol = 4'b0000; pwm = 0; #1;
    check("R7 pol low asserted", {6'b0, d1no, d1nc}, 8'h03);
    @(negedge clk); pwm = 1; #1;
    check("R7 pol low released", {6'b0, d1no, d1nc}, 8'h00);

    // R9 toggle mode on dt1, R10 dt2 independent
    clear_src(); wr(8'b0010_0000);
    check("R9 mode1 eff0", {6'b0, d1no, d1nc}, 8'h01);
    check("R10 dt2 unaffected", {6'b0, d2no, d2nc}, 8'h00);
    wr(8'b0011_1000);
    check("R9 mode1 eff1", {6'b0, d1no, d1nc}, 8'h02);
    check("R10 dt2 own mode", {6'b0, d2no, d2nc}, 8'h01);
    @(negedge clk); s_2 = 4'b0100; act_hi = 4'b0100; pin = 4'b0100; #1;
    check("R10 dt2 own pin", {6'b0, d2no, d2nc}, 8'h02);

    // R11 write effective only after the edge
    clear_src(); wr(8'h00);
    @(negedge clk); wr_en = 1; wr_data = 8'h80; #1;
    check("R11 before edge", {7'b0, sta}, 8'h00);
    @(posedge clk); #1; wr_en = 0;
    check("R11 after edge", {7'b0, sta}, 8'h01);
    shadow = 6'b100000;
    @(negedge clk); #1;
    check("R3 hold", rd_data, 8'h80);

    // random
    for (int it = 0; it < 300; it++) begin
      @(negedge clk);
      pin = $urandom; act_hi = $urandom; pwm = $urandom;
      s_a = $urandom & $urandom; s_b = $urandom & $urandom;
      s_1 = $urandom & $urandom; s_2 = $urandom & $urandom;
      psel = $urandom; ppol = $urandom;
      wr_en = ($urandom % 3) == 0; wr_data = $urandom;
      #1;
      check_out("R4/R5/R6/R7/R8/R9/R10/R11 random pre-edge");
      @(posedge clk); #1;
      if (wr_en) shadow = wr_data[7:2];
      wr_en = 0;
      check("R2/R3 random read", rd_data, {shadow, 2'b00});
      check_out("R4/R8/R9 random post-edge");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule